// File: doc/BRIEF.md
# Time-to-Digital Converter Channel Capture and Serial Readout

This block is one time-to-digital converter channel. It records the arrival time of a pulse as two snapshots, one at the pulse's leading edge and one at its trailing edge. Each snapshot holds the 32 fine-time taps of a delay line and the values of two coarse counters that run in opposite phase. One tap spans about 97.66 ps, so the 32 taps cover one 3.125 ns reference period at 320 MHz. The analog delay line is outside the block; its taps arrive as a 32-bit input vector.

Each snapshot store is also a shift register. When both snapshots are held, the channel raises a ready flag. A shift enable then moves the 192 captured bits out one per clock on a single serial line, so no wide parallel bus is needed. An optional encoder turns each fine snapshot into a 5-bit tap position, which appears on a parallel output when the snapshot is taken. While a store is full, further triggers for it are ignored. This blocks overlapping hits until the data has been read out.

Top module: `tdc_channel`

## Requirements
- R1: After reset, `sdata`, `data_ready` and `done` are 0, and both code outputs are 0.
- R2: In a cycle where `hit_lead` is high and the leading store is empty, the leading store takes `taps`, `coarse_a` and `coarse_b`. The encoded fine position appears on `lead_code` in the following cycle.
- R3: `hit_trail` is captured only when the leading store is already full and the trailing store is empty. A trailing trigger that comes first is ignored and leaves `trail_code` unchanged.
- R4: A trigger that arrives while its store is full is ignored. The stored word and the code output keep their values.
- R5: `data_ready` is high exactly while both stores are full.
- R6: While `data_ready` is high, each cycle with `shift_en` high advances the stream by one bit. The stream order is: leading fine, leading coarse A, leading coarse B, trailing fine, trailing coarse A, trailing coarse B. Each 32-bit word goes MSB first, giving 192 bits. `sdata` shows the current bit before the edge that consumes it, and is 0 while not ready.
- R7: `done` is high for exactly one cycle, the cycle after the edge that consumes the 192nd bit. In that same cycle `data_ready` is low and both stores are empty again.
- R8: The fine code is the lowest index i in 0..30 with tap i = 1 and tap i+1 = 0. If no such index exists, the code is 0. When the encoder is disabled by parameter, the code is always 0.
- R9: A cycle with `shift_en` low leaves the stream position and `sdata` unchanged. `shift_en` while not ready has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture and shift clock |
| rst | input | 1 | Synchronous active-high reset |
| taps | input | 32 | Delay-line tap snapshot (fine time) |
| coarse_a | input | 32 | Coarse counter, phase A |
| coarse_b | input | 32 | Coarse counter, opposite phase B |
| hit_lead | input | 1 | Leading-edge trigger |
| hit_trail | input | 1 | Trailing-edge trigger |
| shift_en | input | 1 | Advance the serial stream one bit |
| sdata | output | 1 | Serial readout bit |
| lead_code | output | 5 | Encoded fine position of the leading snapshot |
| trail_code | output | 5 | Encoded fine position of the trailing snapshot |
| data_ready | output | 1 | Both snapshots held, readout possible |
| done | output | 1 | One-cycle pulse after the last bit |

## Verification
The hardest state to reach is a full store being hit again while it waits for readout. A wrong re-arm would not change the flags; it would only corrupt bits deep in the 192-bit stream. The bench fires a second leading trigger with different data before the trailing one. It also fires a trailing trigger before any leading one. It then reads the whole stream and compares every bit. One readout pauses `shift_en` at several points, including the boundary between the two stores, to show that the position holds across a gap.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
    localparam int TAPS    = 32;
    localparam int CNT_W   = 32;
    localparam int CODE_W  = $clog2(TAPS);
    localparam int WORD_W  = TAPS + 2 * CNT_W;
    localparam int TOTAL_W = 2 * WORD_W;
    localparam int POS_W   = $clog2(TOTAL_W);

    typedef struct packed {
        logic [TAPS-1:0]  fine;
        logic [CNT_W-1:0] ca;
        logic [CNT_W-1:0] cb;
    } hit_word_t;

    // lowest i with t[i]=1 and t[i+1]=0; 0 when none
    function automatic logic [CODE_W-1:0] fall_index(input logic [TAPS-1:0] t);
        logic [CODE_W-1:0] r;
        r = '0;
        for (int i = TAPS - 2; i >= 0; i--) begin
            if (t[i] && !t[i+1]) r = CODE_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/tdc_hit_set.sv
module tdc_hit_set
    import tdc_pkg::*;
#(
    parameter bit ENC_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              shift,
    input  logic              clear,
    input  hit_word_t         word_in,
    output logic              valid,
    output logic              msb,
    output logic [CODE_W-1:0] code
);
    logic [WORD_W-1:0] sr;
    logic [CODE_W-1:0] enc;

    generate
        if (ENC_EN) begin : g_enc
            assign enc = fall_index(word_in.fine);
        end else begin : g_noenc
            assign enc = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sr    <= '0;
            valid <= 1'b0;
            code  <= '0;
        end else begin
            if (clear) begin
                valid <= 1'b0;
            end else if (arm) begin
                valid <= 1'b1;
            end
            if (arm) begin
                sr   <= word_in;
                code <= enc;
            end else if (shift) begin
                sr <= {sr[WORD_W-2:0], 1'b0};
            end
        end
    end

    assign msb = sr[WORD_W-1];

    p_hold_full_r4: assert property (@(posedge clk) disable iff (rst)
        (valid && !shift && !clear) |=> ($stable(sr) && $stable(code) && valid));
    p_arm_only_empty_r4: assert property (@(posedge clk) disable iff (rst)
        arm |-> !valid);
    p_code_range_r8: assert property (@(posedge clk) disable iff (rst)
        code <= CODE_W'(TAPS - 2));
endmodule

// File: rtl/tdc_readout_ctrl.sv
module tdc_readout_ctrl
    import tdc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ready,
    input  logic shift_en,
    input  logic lead_msb,
    input  logic trail_msb,
    output logic shift_lead,
    output logic shift_trail,
    output logic clear,
    output logic sdata,
    output logic done
);
    logic [POS_W-1:0] pos;
    logic step, last, in_lead;

    assign step        = ready && shift_en;
    assign last        = (pos == POS_W'(TOTAL_W - 1));
    assign in_lead     = (pos < POS_W'(WORD_W));
    assign shift_lead  = step && in_lead;
    assign shift_trail = step && !in_lead;
    assign clear       = step && last;
    assign sdata       = ready ? (in_lead ? lead_msb : trail_msb) : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos  <= '0;
            done <= 1'b0;
        end else begin
            done <= clear;
            if (step) pos <= last ? '0 : pos + 1'b1;
        end
    end

    p_idle_holds_r9: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pos));
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_follows_last_r7: assert property (@(posedge clk) disable iff (rst)
        (step && last) |=> (done && pos == '0));
endmodule

// File: rtl/tdc_channel.sv
module tdc_channel
    import tdc_pkg::*;
#(
    parameter bit ENC_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TAPS-1:0]   taps,
    input  logic [CNT_W-1:0]  coarse_a,
    input  logic [CNT_W-1:0]  coarse_b,
    input  logic              hit_lead,
    input  logic              hit_trail,
    input  logic              shift_en,
    output logic              sdata,
    output logic [CODE_W-1:0] lead_code,
    output logic [CODE_W-1:0] trail_code,
    output logic              data_ready,
    output logic              done
);
    localparam int NSETS = 2;   // index 0 = leading, 1 = trailing

    hit_word_t         word;
    logic              arm   [NSETS];
    logic              shift [NSETS];
    logic              full  [NSETS];
    logic              msb   [NSETS];
    logic [CODE_W-1:0] code  [NSETS];
    logic              clear;

    assign word   = '{fine: taps, ca: coarse_a, cb: coarse_b};
    assign arm[0] = hit_lead && !full[0];
    assign arm[1] = hit_trail && full[0] && !full[1];

    generate
        for (genvar g = 0; g < NSETS; g++) begin : g_set
            tdc_hit_set #(.ENC_EN(ENC_EN)) u_set (
                .clk     (clk),
                .rst     (rst),
                .arm     (arm[g]),
                .shift   (shift[g]),
                .clear   (clear),
                .word_in (word),
                .valid   (full[g]),
                .msb     (msb[g]),
                .code    (code[g])
            );
        end
    endgenerate

    assign data_ready = full[0] && full[1];
    assign lead_code  = code[0];
    assign trail_code = code[1];

    tdc_readout_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ready       (data_ready),
        .shift_en    (shift_en),
        .lead_msb    (msb[0]),
        .trail_msb   (msb[1]),
        .shift_lead  (shift[0]),
        .shift_trail (shift[1]),
        .clear       (clear),
        .sdata       (sdata),
        .done        (done)
    );

    p_trail_needs_lead_r3: assert property (@(posedge clk) disable iff (rst)
        full[1] |-> full[0]);
    p_done_not_ready_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !data_ready);
    p_ready_sdata_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !data_ready |-> !sdata);
endmodule

// File: tb/tdc_channel_test.sv
module tdc_channel_test;
    typedef struct packed {
        logic [31:0] lf, la, lb, tf, ta, tb;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_00FF, 32'h1234_5678, 32'h8765_4321, 32'h0001_FFFE, 32'hDEAD_BEEF, 32'h0BAD_F00D},
        '{32'hFFFF_FFFF, 32'h0000_0001, 32'h8000_0000, 32'h0000_0000, 32'hA5A5_5A5A, 32'h3C3C_C3C3},
        '{32'h7FFF_FFFF, 32'hFFFF_FFFE, 32'h0000_0003, 32'h0F0F_0F0F, 32'h1111_2222, 32'h3333_4444},
        '{32'hFFFF_0000, 32'hCAFE_F00D, 32'h5555_AAAA, 32'h0000_0001, 32'h0000_0000, 32'hFFFF_FFFF}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic [31:0] taps = '0, coarse_a = '0, coarse_b = '0;
    logic hit_lead = 1'b0, hit_trail = 1'b0, shift_en = 1'b0;
    logic sdata, data_ready, done;
    logic [4:0] lead_code, trail_code;
    int checks = 0, fails = 0, cycles = 0;

    always #2.5 clk = ~clk;

    tdc_channel uut (
        .clk(clk), .rst(rst), .taps(taps), .coarse_a(coarse_a), .coarse_b(coarse_b),
        .hit_lead(hit_lead), .hit_trail(hit_trail), .shift_en(shift_en),
        .sdata(sdata), .lead_code(lead_code), .trail_code(trail_code),
        .data_ready(data_ready), .done(done)
    );

    function automatic logic [4:0] ref_code(input logic [31:0] t);
        int i;
        i = 0;
        while (i < 31) begin
            if (t[i] == 1'b1 && t[i+1] == 1'b0) return 5'(i);
            i++;
        end
        return 5'd0;
    endfunction

    task automatic check(input string req, input logic [191:0] act, input logic [191:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse(input bit lead, input logic [31:0] f, a, b);
        @(negedge clk);
        taps = f; coarse_a = a; coarse_b = b;
        hit_lead = lead; hit_trail = !lead;
        @(negedge clk);
        hit_lead = 1'b0; hit_trail = 1'b0;
    endtask

    // reads 192 bits; pauses shift_en at the given positions when pause set
    task automatic read_stream(input logic [191:0] exp, input bit pause, input string tag);
        logic [191:0] got;
        got = '0;
        for (int n = 0; n < 192; n++) begin
            if (pause && (n == 5 || n == 96 || n == 150)) begin
                logic held;
                held = sdata;
                shift_en = 1'b0;
                @(negedge clk);
                @(negedge clk);
                check("R9 hold with shift_en low", {191'd0, sdata}, {191'd0, held});
            end
            got[191-n] = sdata;
            shift_en = 1'b1;
            @(negedge clk);
        end
        shift_en = 1'b0;
        check({"R6 stream ", tag}, got, exp);
        check("R7 done after last bit", {190'd0, done, data_ready}, {190'd0, 1'b1, 1'b0});
        @(negedge clk);
        check("R7 done one cycle", {191'd0, done}, 192'd0);
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state", {179'd0, sdata, data_ready, done, lead_code, trail_code}, 192'd0);

        // shift_en without ready: no effect
        shift_en = 1'b1;
        repeat (4) @(negedge clk);
        shift_en = 1'b0;

        for (int v = 0; v < NV; v++) begin
            vec_t x;
            x = VECS[v];
            pulse(1'b1, x.lf, x.la, x.lb);
            check("R2 lead code", {187'd0, lead_code}, {187'd0, ref_code(x.lf)});
            check("R5 not ready after lead only", {191'd0, data_ready}, 192'd0);
            pulse(1'b0, x.tf, x.ta, x.tb);
            check("R8 trail code", {187'd0, trail_code}, {187'd0, ref_code(x.tf)});
            check("R5 ready with both", {191'd0, data_ready}, {191'd0, 1'b1});
            read_stream({x.lf, x.la, x.lb, x.tf, x.ta, x.tb}, v == 1, "table");
        end

        // R3: trail before lead is ignored
        pulse(1'b0, 32'h0000_0007, 32'h1, 32'h2);
        check("R3 early trail ignored", {186'd0, data_ready, trail_code},
              {186'd0, 1'b0, ref_code(VECS[NV-1].tf)});
        // R4: second lead while full is ignored
        pulse(1'b1, 32'h0000_003F, 32'hAAAA_0001, 32'hBBBB_0002);
        pulse(1'b1, 32'h0000_0FFF, 32'h9999_9999, 32'h7777_7777);
        check("R4 relead code kept", {187'd0, lead_code}, {187'd0, 5'd5});
        pulse(1'b0, 32'h0007_FFFF, 32'hCCCC_0003, 32'hDDDD_0004);
        pulse(1'b0, 32'h0000_0001, 32'h0, 32'h0);
        check("R4 retrail code kept", {187'd0, trail_code}, {187'd0, 5'd18});
        shift_en = 1'b1;   // R9: enabled while ready, checked inside stream
        shift_en = 1'b0;
        read_stream({32'h0000_003F, 32'hAAAA_0001, 32'hBBBB_0002,
                     32'h0007_FFFF, 32'hCCCC_0003, 32'hDDDD_0004}, 1'b0, "R4 first data kept");

        // R7: new capture after readout
        pulse(1'b1, 32'h0000_0003, 32'h5, 32'h6);
        check("R7 recapture after done", {187'd0, lead_code}, {187'd0, 5'd1});

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule